// File: doc/BRIEF.md
# Frame Error Scorer with Selectable Comparison Source

This block scores a candidate image filter. It accumulates the sum of absolute differences between the filter's output pixels and a second pixel stream, over exactly one image frame. A lower score means a better filter. The second stream can come from one of three places, chosen by a mode input: a golden reference image, the pixel that entered the filter itself, or the output of a neighbouring filter. Using the neighbour as the comparison source lets one filter learn to copy another, with a score that tends toward zero, and no reference data is needed.

The filter under test has a pipeline latency. The comparison stream therefore enters a delay line whose length is set by a configuration input, from 0 to 31 cycles. An array pixel is counted only in a cycle where it meets a delayed comparison pixel. The comparison side has no back-pressure: `cmp_ready` is always high. The array side is accepted (`res_ready` high) only in cycles where an aligned comparison pixel leaves the delay line. A producer on the array side must therefore present its pixel in the same cycle as its delayed partner. A pixel offered at any other time is refused and not counted. The block also measures the distance in cycles between the two start-of-frame markers, so that software can read the latency and program the delay.

Top module: `frame_err_score`

## Requirements
- R1: After reset, `fitness` is 0, `done` is 0, `lat_cycles` is 0, and `res_ready` is 0 until a comparison pixel has reached the delay tap.
- R2: With `cfg_mode` = 0, each counted pair adds |`res_pix` − `ref_pix`| to the frame score.
- R3: With `cfg_mode` = 1, each counted pair adds |`res_pix` − `own_pix`|.
- R4: With `cfg_mode` = 2, each counted pair adds |`res_pix` − `nbr_pix`|. Identical streams give a score of 0.
- R5: `cfg_mode` = 3 behaves exactly like mode 0 (the reference source).
- R6: The comparison pixel, its valid and its start marker reach the comparator exactly `cfg_delay` cycles after `cmp_valid` accepted them. This holds for any delay from 0 to 31, including both ends.
- R7: `res_ready` is high exactly when a delayed comparison pixel is present. An array pixel offered without such a partner is not counted.
- R8: A comparison pixel with `cmp_sof` = 1 restarts the score and the pixel count. It discards any partial frame. Pairs that arrive while no frame is open never produce a result.
- R9: After IMG_W×IMG_H counted pairs, `done` is high for exactly one cycle, the cycle after the last pair. `fitness` takes the frame score in that same cycle and holds it until the next `done`.
- R10: The score register is PIX_W + log2(IMG_W×IMG_H) bits wide. A frame where every pixel differs by the full scale is reported exactly, without wrapping.
- R11: `lat_cycles` reports the number of cycles from an accepted comparison start marker to an accepted array start marker. It is 0 when both arrive in the same cycle, and it saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Comparison source: 0 reference, 1 own input, 2 neighbour, 3 reference |
| cfg_delay | input | DLY_W | Alignment delay in cycles, 0 to MAX_DLY |
| cmp_valid | input | 1 | Comparison lane pixel valid |
| cmp_ready | output | 1 | Always high; the comparison side is never stalled |
| cmp_sof | input | 1 | First pixel of a frame on the comparison lane |
| ref_pix | input | PIX_W | Reference image pixel |
| own_pix | input | PIX_W | Pixel fed into the filter under test |
| nbr_pix | input | PIX_W | Output pixel of the neighbouring filter |
| res_valid | input | 1 | Filter-under-test output pixel valid |
| res_ready | output | 1 | Array pixel accepted this cycle |
| res_sof | input | 1 | First pixel of a frame on the array lane |
| res_pix | input | PIX_W | Output pixel of the filter under test |
| fitness | output | ACC_W | Score of the last completed frame |
| done | output | 1 | One-cycle pulse when a frame score is ready |
| lat_cycles | output | LAT_W | Measured start-marker distance in cycles |

## Verification
The checker assumes that `cmp_valid` stays low during reset. It also assumes that `cfg_mode` and `cfg_delay` are changed only while no comparison pixel is inside the delay line. The delay-alignment property is enabled only after the delay has held the same value for a cycle. The stimulus models the filter as a fixed latency: it replays the comparison schedule on the array lane exactly `cfg_delay` cycles later. It changes configuration only after more than 31 idle cycles. Bubbles, aborted partial frames, stray pairs with no frame open, and refused array pixels are driven on purpose to exercise R7 and R8.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [1:0] {
    SRC_REF = 2'd0,
    SRC_OWN = 2'd1,
    SRC_NBR = 2'd2,
    SRC_ALT = 2'd3
  } src_sel_e;

endpackage

// File: rtl/fes_src_mux.sv
module fes_src_mux
  import fes_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [1:0]       mode,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic [PIX_W-1:0] own_pix,
  input  logic [PIX_W-1:0] nbr_pix,
  output logic [PIX_W-1:0] sel_pix
);

  src_sel_e mode_e;

  always_comb begin
    mode_e = src_sel_e'(mode);
    unique case (mode_e)
      SRC_OWN: sel_pix = own_pix;
      SRC_NBR: sel_pix = nbr_pix;
      default: sel_pix = ref_pix;
    endcase
  end

endmodule

// File: rtl/fes_delay_line.sv
module fes_delay_line #(
  parameter int W     = 9,
  parameter int DEPTH = 31,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  output logic [W-1:0]     out_data
);

  generate
    if (DEPTH < 1) begin : g_wire
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end else begin : g_shift
      logic [DEPTH-1:0] v_q;
      logic [W-1:0]     d_q [DEPTH];

      always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else if (DEPTH == 1) v_q <= in_valid;
        else v_q <= {v_q[DEPTH-2:0], in_valid};
      end

      always_ff @(posedge clk) begin
        d_q[0] <= in_data;
        for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
      end

      always_comb begin
        int idx;
        idx = int'(sel);
        if (idx == 0 || idx > DEPTH) begin
          out_valid = in_valid;
          out_data  = in_data;
        end else begin
          out_valid = v_q[idx-1];
          out_data  = d_q[idx-1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/fes_accum.sv
module fes_accum #(
  parameter int PIX_W  = 8,
  parameter int PIXELS = 16384,
  parameter int ACC_W  = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             first,
  input  logic [PIX_W-1:0] a_pix,
  input  logic [PIX_W-1:0] b_pix,
  output logic [ACC_W-1:0] fitness,
  output logic             done
);

  localparam int CNT_W = $clog2(PIXELS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PIXELS);

  logic [PIX_W-1:0] diff;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             open_q;
  logic             take;

  always_comb begin
    diff = (a_pix > b_pix) ? (a_pix - b_pix) : (b_pix - a_pix);
    take = fire && (first || open_q);
    if (first) begin
      acc_nxt = ACC_W'(diff);
      cnt_nxt = CNT_W'(1);
    end else begin
      acc_nxt = acc_q + ACC_W'(diff);
      cnt_nxt = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      open_q  <= 1'b0;
      fitness <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        acc_q <= acc_nxt;
        cnt_q <= cnt_nxt;
        if (cnt_nxt == LAST) begin
          fitness <= acc_nxt;
          done    <= 1'b1;
          open_q  <= 1'b0;
        end else begin
          open_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fes_lat_meter.sv
module fes_lat_meter #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_sof,
  input  logic             tail_sof,
  output logic [LAT_W-1:0] lat_cycles
);

  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic [LAT_W-1:0] run_cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      running    <= 1'b0;
      lat_cycles <= '0;
    end else begin
      if (tail_sof) begin
        lat_cycles <= head_sof ? '0 : run_cnt;
        running    <= 1'b0;
      end else if (head_sof) begin
        run_cnt <= LAT_W'(1);
        running <= 1'b1;
      end else if (running && run_cnt != LAT_MAX) begin
        run_cnt <= run_cnt + LAT_W'(1);
      end
    end
  end

endmodule

// File: rtl/frame_err_score.sv
module frame_err_score #(
  parameter int IMG_W   = 128,
  parameter int IMG_H   = 128,
  parameter int PIX_W   = 8,
  parameter int MAX_DLY = 31,
  parameter int LAT_W   = 6,
  parameter int DLY_W   = $clog2(MAX_DLY + 1),
  parameter int ACC_W   = PIX_W + $clog2(IMG_W * IMG_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic             cmp_sof,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic [PIX_W-1:0] own_pix,
  input  logic [PIX_W-1:0] nbr_pix,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic             res_sof,
  input  logic [PIX_W-1:0] res_pix,
  output logic [ACC_W-1:0] fitness,
  output logic             done,
  output logic [LAT_W-1:0] lat_cycles
);

  localparam int PIXELS = IMG_W * IMG_H;

  logic [PIX_W-1:0] sel_pix;
  logic             dly_valid;
  logic [PIX_W:0]   dly_data;
  logic             pair_fire;

  fes_src_mux #(.PIX_W(PIX_W)) u_mux (
    .mode    (cfg_mode),
    .ref_pix (ref_pix),
    .own_pix (own_pix),
    .nbr_pix (nbr_pix),
    .sel_pix (sel_pix)
  );

  fes_delay_line #(.W(PIX_W + 1), .DEPTH(MAX_DLY), .SEL_W(DLY_W)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cfg_delay),
    .in_valid  (cmp_valid),
    .in_data   ({cmp_sof, sel_pix}),
    .out_valid (dly_valid),
    .out_data  (dly_data)
  );

  assign cmp_ready = 1'b1;
  assign res_ready = dly_valid;
  assign pair_fire = dly_valid && res_valid;

  fes_accum #(.PIX_W(PIX_W), .PIXELS(PIXELS), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (pair_fire),
    .first   (dly_data[PIX_W]),
    .a_pix   (res_pix),
    .b_pix   (dly_data[PIX_W-1:0]),
    .fitness (fitness),
    .done    (done)
  );

  fes_lat_meter #(.LAT_W(LAT_W)) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_sof   (cmp_valid && cmp_sof),
    .tail_sof   (pair_fire && res_sof),
    .lat_cycles (lat_cycles)
  );

endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
  parameter int PIXELS = 16384,
  parameter int PIX_W  = 8,
  parameter int ACC_W  = 22,
  parameter int LAT_W  = 6,
  parameter int DLY_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DLY_W-1:0] cfg_delay,
  input logic             cmp_valid,
  input logic             cmp_sof,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_sof,
  input logic [ACC_W-1:0] fitness,
  input logic             done,
  input logic [LAT_W-1:0] lat_cycles
);

  localparam longint MAX_SUM = longint'(PIXELS) * ((longint'(1) << PIX_W) - 1);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_FIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(fitness)); // R9

  AST_DONE_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid && res_ready)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(fitness) <= MAX_SUM); // R10

  AST_ALIGN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_delay == DLY_W'(1) && $past(cfg_delay) == DLY_W'(1)) |-> (res_ready == $past(cmp_valid))); // R6

  AST_LAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_sof && res_valid && res_ready && res_sof) |=> (lat_cycles == '0)); // R11

endmodule

bind frame_err_score fes_chk #(
  .PIXELS (IMG_W * IMG_H),
  .PIX_W  (PIX_W),
  .ACC_W  (ACC_W),
  .LAT_W  (LAT_W),
  .DLY_W  (DLY_W)
) u_fes_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_delay  (cfg_delay),
  .cmp_valid  (cmp_valid),
  .cmp_sof    (cmp_sof),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_sof    (res_sof),
  .fitness    (fitness),
  .done       (done),
  .lat_cycles (lat_cycles)
);

// File: tb/test_frame_err_score.sv
`timescale 1ns/1ps
module test_frame_err_score;

  localparam int IW = 4, IH = 4, PW = 8, MD = 31, LW = 6;
  localparam int N  = IW * IH;
  localparam int DW = $clog2(MD + 1);
  localparam int AW = PW + $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = '0;
  logic [DW-1:0] cfg_delay = '0;
  logic          cmp_valid = 1'b0, cmp_sof = 1'b0;
  logic          cmp_ready;
  logic [PW-1:0] ref_pix = '0, own_pix = '0, nbr_pix = '0, res_pix = '0;
  logic          res_valid = 1'b0, res_sof = 1'b0;
  logic          res_ready;
  logic [AW-1:0] fitness;
  logic          done;
  logic [LW-1:0] lat_cycles;

  int checks = 0, errors = 0, cyc = 0, dones_seen = 0;
  int    q_fit[$];
  int    q_cyc[$];
  int    q_lat[$];
  string q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_err_score #(.IMG_W(IW), .IMG_H(IH), .PIX_W(PW), .MAX_DLY(MD), .LAT_W(LW)) i_frame_err_score (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_delay(cfg_delay),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_sof(cmp_sof),
    .ref_pix(ref_pix), .own_pix(own_pix), .nbr_pix(nbr_pix),
    .res_valid(res_valid), .res_ready(res_ready), .res_sof(res_sof), .res_pix(res_pix),
    .fitness(fitness), .done(done), .lat_cycles(lat_cycles)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // pixel generator: id >= 100 marks garbage leading pixels
  function automatic int pv(input int lane, input int id, input int pat);
    if (id >= 100 || pat == 2) return (lane == 3) ? 255 : 0;
    case (lane)
      0: return (id * 29 + 7) & 255;
      1: return (id * 13) & 255;
      2: return (pat == 1) ? ((id * 41 + 3) & 255) : ((id * 53 + 90) & 255);
      default: return (id * 41 + 3) & 255;
    endcase
  endfunction

  // drives one frame; modes 0/3 -> lane 0, 1 -> lane 1, 2 -> lane 2
  task automatic run_frame(input int mode, input int dly, input int pat,
                           input bit gaps, input int pre, input string tag);
    int slot[128];
    int ns = 0, exp_sum = 0, lane;
    lane = (mode == 3) ? 0 : mode;
    for (int g = 0; g < pre; g++) begin slot[ns] = 100 + g; ns++; end
    for (int k = 0; k < N; k++) begin
      if (gaps && (k % 5 == 3)) begin slot[ns] = -1; ns++; end
      slot[ns] = k; ns++;
      exp_sum += (pv(3, k, pat) > pv(lane, k, pat)) ? pv(3, k, pat) - pv(lane, k, pat)
                                                     : pv(lane, k, pat) - pv(3, k, pat);
    end
    @(negedge clk);
    cfg_mode  = 2'(mode);
    cfg_delay = DW'(dly);
    q_fit.push_back(exp_sum);
    q_lat.push_back(dly);
    q_tag.push_back(tag);
    for (int c = 0; c < ns + dly; c++) begin
      @(negedge clk);
      cmp_valid = 1'b0; cmp_sof = 1'b0;
      res_valid = 1'b0; res_sof = 1'b0;
      if (c < ns && slot[c] >= 0) begin
        cmp_valid = 1'b1;
        cmp_sof   = (slot[c] == 0 || slot[c] == 100);
        ref_pix   = PW'(pv(0, slot[c], pat));
        own_pix   = PW'(pv(1, slot[c], pat));
        nbr_pix   = PW'(pv(2, slot[c], pat));
      end
      if (c >= dly && slot[c-dly] >= 0) begin
        res_valid = 1'b1;
        res_sof   = (slot[c-dly] == 0 || slot[c-dly] == 100);
        res_pix   = PW'(pv(3, slot[c-dly], pat));
        if (slot[c-dly] == N - 1) begin
          q_cyc.push_back(cyc);
          #1 check(res_ready == 1'b1, "R7 ready with aligned partner", int'(res_ready), 1);
        end
      end
    end
    @(negedge clk);
    cmp_valid = 1'b0; cmp_sof = 1'b0; res_valid = 1'b0; res_sof = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // scoreboard monitor
  bit done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) check(done == 1'b0, "R9 done width", int'(done), 0);
      if (done) begin
        dones_seen++;
        if (q_fit.size() == 0) begin
          check(1'b0, "R8/R9 unexpected done", 1, 0);
        end else begin
          int ef, ec, el;
          string t;
          ef = q_fit.pop_front(); ec = q_cyc.pop_front();
          el = q_lat.pop_front(); t = q_tag.pop_front();
          check(int'(fitness) == ef, t, int'(fitness), ef);
          check(cyc == ec + 1, "R9 done timing", cyc, ec + 1);
          check(int'(lat_cycles) == el, "R11 latency", int'(lat_cycles), el);
        end
      end
    end
    done_prev = done;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fitness == '0, "R1 fitness", int'(fitness), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(lat_cycles == '0, "R1 lat", int'(lat_cycles), 0);
    check(res_ready == 1'b0, "R1 res_ready", int'(res_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: array pixels with no comparison partner are refused
    cfg_delay = DW'(3);
    res_valid = 1'b1; res_sof = 1'b1; res_pix = 8'd200;
    repeat (4) begin
      @(negedge clk);
      check(res_ready == 1'b0, "R7 refused without partner", int'(res_ready), 0);
    end
    res_valid = 1'b0; res_sof = 1'b0;
    check(done == 1'b0 && fitness == '0, "R7 nothing counted", int'(fitness), 0);

    run_frame(0, 0,  0, 1'b0, 0, "R2 reference mode delay 0");
    run_frame(0, 5,  0, 1'b1, 0, "R2 reference mode with bubbles R6");
    run_frame(1, 31, 0, 1'b0, 0, "R3 own-input mode R6 max delay");
    run_frame(2, 2,  1, 1'b0, 0, "R4 neighbour identical gives zero");
    run_frame(2, 7,  0, 1'b1, 0, "R4 neighbour differing");
    run_frame(3, 4,  0, 1'b0, 0, "R5 mode 3 equals reference");
    run_frame(0, 1,  2, 1'b0, 0, "R10 full-scale frame no wrap");
    run_frame(1, 3,  0, 1'b0, 7, "R8 restart discards partial frame");

    // R8: pairs with no frame open never yield a result
    cfg_delay = DW'(0);
    for (int k = 0; k < N + 4; k++) begin
      @(negedge clk);
      cmp_valid = 1'b1; cmp_sof = 1'b0; ref_pix = 8'd9;
      res_valid = 1'b1; res_sof = 1'b0; res_pix = 8'd1;
    end
    @(negedge clk);
    cmp_valid = 1'b0; res_valid = 1'b0;
    repeat (5) @(negedge clk);

    check(q_fit.size() == 0, "R9 all frames scored", q_fit.size(), 0);
    check(dones_seen == 8, "R8 done count", dones_seen, 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule